// File: doc/BRIEF.md
# Reverse Phase-Cut Ramp Sequencer

This block replaces the capacitor ramp of a reverse phase-cut dimmer controller with a digital accumulator. Each mains half-wave begins with a zero-crossing strobe. The ramp first climbs at a fast rate until it passes a low fixed turn-on level. At that point the gate drive switches on and the ramp slows to the base rate.

The gate stays on until the slow ramp reaches the externally supplied control level, which sets the conduction angle. The gate then switches off. The ramp finishes at the fast rate up to an end level, is cleared in one discharge cycle, and the sequencer waits for the next crossing.

A gate-inhibit input, for example an undervoltage flag from the supply monitor, blanks the gate for the rest of the current half-wave only. An enable input decides whether a crossing starts a half-wave at all.

Top module: `phase_ramp_seq`

## Requirements
- R1: While idle (state code 0), a cycle with `zc_stb` and `en` both high moves the state to the fast pre-conduction ramp (code 1) on the next cycle. A strobe while `en` is low leaves the block idle.
- R2: The pre-conduction ramp rises by FAST_STEP (4) per cycle from zero. It lasts ceil(ON_LVL/4) cycles, which is 92 cycles with ON_LVL = 368.
- R3: `gate_out` is high only in the conducting state (code 2). In that state the ramp rises by SLOW_STEP (1) per cycle, so a level `ctrl_lvl` above ON_LVL gives a gate pulse of exactly ctrl_lvl − ON_LVL cycles.
- R4: After turn-off, the fast post-conduction ramp (code 3) runs from the ramp value at turn-off up to END_LVL (4000) at 4 per cycle. For a control level between ON_LVL and END_LVL this takes ceil((END_LVL − ctrl_lvl)/4) cycles, and ceil((END_LVL − ON_LVL)/4) cycles when no conduction took place.
- R5: The discharge state (code 4) lasts exactly one cycle, clears the ramp, and returns to idle.
- R6: `gate_inh` forces `gate_out` low in the same cycle. The gate stays low for the rest of that half-wave, while the state sequence keeps its normal timing. The next half-wave conducts normally.
- R7: A zero-crossing strobe that arrives in any state other than idle has no effect on the sequence or on the gate width.
- R8: If `ctrl_lvl` ≤ ON_LVL, the gate never turns on in that half-wave, and the pre-conduction ramp passes straight to the post-conduction ramp.
- R9: After synchronous reset the state is idle (code 0) and `gate_out` is low, including when reset is applied in the middle of a half-wave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| zc_stb | input | 1 | One-cycle zero-crossing strobe |
| ctrl_lvl | input | 12 | Control level that sets the turn-off point |
| en | input | 1 | Allows a crossing to start a half-wave |
| gate_inh | input | 1 | Blanks the gate for the rest of the half-wave |
| gate_out | output | 1 | Power-switch gate drive |
| state_o | output | 3 | Sequencer state: 0 idle, 1 pre, 2 conduct, 3 post, 4 discharge |

## Verification
The assertions check the following on every cycle:
- the gate is high only in the conducting state;
- an inhibit drops the gate at once and keeps it low in the next cycle;
- idle holds without an enabled strobe and leaves with one;
- discharge is a single cycle;
- a low control level never reaches conduction.

The ramp slopes, the exact gate-pulse width against the control word, and the length of the post-conduction ramp can only be shown by the bench. It measures phase durations through the state output across several control words, the boundary levels, and inhibit and stray-strobe scenarios.

// File: rtl/prs_pkg.sv
// Shared types for the reverse phase-cut ramp sequencer.
package prs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_COND  = 3'd2,
        ST_POST  = 3'd3,
        ST_DISCH = 3'd4
    } prs_state_e;
endpackage

// File: rtl/prs_ramp_acc.sv
// Ramp accumulator: adds a fast or slow step per cycle while running,
// saturating at the full-scale value; clear has priority over run.
// Assumes FAST_STEP and SLOW_STEP fit within RW bits.
module prs_ramp_acc #(
    parameter int RW        = 12,
    parameter int FAST_STEP = 4,
    parameter int SLOW_STEP = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          run,
    input  logic          fast,
    output logic [RW-1:0] ramp_nxt
);
    localparam logic [RW:0] F_INC = (RW+1)'(FAST_STEP);
    localparam logic [RW:0] S_INC = (RW+1)'(SLOW_STEP);
    localparam logic [RW:0] FULL  = {1'b0, {RW{1'b1}}};

    logic [RW-1:0] ramp_q;
    logic [RW:0]   sum;

    // Next ramp value with saturation at full scale.
    always_comb begin
        sum = {1'b0, ramp_q} + (fast ? F_INC : S_INC);
        if (sum > FULL) ramp_nxt = FULL[RW-1:0];
        else            ramp_nxt = sum[RW-1:0];
    end

    // Ramp register: clear, advance or hold.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) ramp_q <= '0;
        else if (run)      ramp_q <= ramp_nxt;
    end
endmodule

// File: rtl/prs_level_cmp.sv
// Level comparators: compare the next ramp value against the turn-on,
// control and end levels, and flag a control level too low to conduct.
// Assumes ON_LVL < END_LVL and both fit within RW bits.
module prs_level_cmp #(
    parameter int RW      = 12,
    parameter int ON_LVL  = 368,
    parameter int END_LVL = 4000
) (
    input  logic [RW-1:0] ramp_nxt,
    input  logic [RW-1:0] ctrl_lvl,
    output logic          on_hit,
    output logic          off_hit,
    output logic          end_hit,
    output logic          ctrl_low
);
    localparam logic [RW-1:0] ON_V  = RW'(ON_LVL);
    localparam logic [RW-1:0] END_V = RW'(END_LVL);

    // Threshold crossings evaluated on the value the ramp is about to take.
    always_comb begin
        on_hit   = ramp_nxt >= ON_V;
        off_hit  = ramp_nxt >= ctrl_lvl;
        end_hit  = ramp_nxt >= END_V;
        ctrl_low = ctrl_lvl <= ON_V;
    end
endmodule

// File: rtl/prs_seq_fsm.sv
// Half-wave sequencer: idle -> fast pre-ramp -> slow conduct -> fast
// post-ramp -> one-cycle discharge -> idle. Holds the per-half-wave gate
// block set by the inhibit input. Assumes zc_stb is a one-cycle strobe.
module prs_seq_fsm
    import prs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       zc_stb,
    input  logic       en,
    input  logic       gate_inh,
    input  logic       on_hit,
    input  logic       off_hit,
    input  logic       end_hit,
    input  logic       ctrl_low,
    output prs_state_e state,
    output logic       run,
    output logic       fast,
    output logic       clr,
    output logic       gate
);
    prs_state_e st_q, st_d;
    logic       blk_q;

    // Next-state selection from threshold flags.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (zc_stb && en) st_d = ST_PRE;
            ST_PRE:   if (on_hit)       st_d = ctrl_low ? ST_POST : ST_COND;
            ST_COND:  if (off_hit)      st_d = ST_POST;
            ST_POST:  if (end_hit)      st_d = ST_DISCH;
            ST_DISCH:                   st_d = ST_IDLE;
            default:                    st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Gate block: set by inhibit inside a half-wave, cleared at discharge.
    always_ff @(posedge clk) begin
        if (!rst_n || st_q == ST_DISCH || st_q == ST_IDLE) blk_q <= 1'b0;
        else if (gate_inh)                                 blk_q <= 1'b1;
    end

    // Ramp controls and gate drive.
    always_comb begin
        run   = (st_q == ST_PRE) || (st_q == ST_COND) || (st_q == ST_POST);
        fast  = (st_q != ST_COND);
        clr   = (st_q == ST_DISCH) || (st_q == ST_IDLE);
        gate  = (st_q == ST_COND) && !blk_q && !gate_inh;
        state = st_q;
    end
endmodule

// File: rtl/phase_ramp_seq.sv
// Top of the reverse phase-cut ramp sequencer: joins the ramp accumulator,
// the level comparators and the half-wave state machine. Assumes the
// control level is held steady within a half-wave.
module phase_ramp_seq
    import prs_pkg::*;
#(
    parameter int RW        = 12,
    parameter int FAST_STEP = 4,
    parameter int SLOW_STEP = 1,
    parameter int ON_LVL    = 368,
    parameter int END_LVL   = 4000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          zc_stb,
    input  logic [RW-1:0] ctrl_lvl,
    input  logic          en,
    input  logic          gate_inh,
    output logic          gate_out,
    output logic [2:0]    state_o
);
    logic [RW-1:0] ramp_nxt;
    logic          on_hit, off_hit, end_hit, ctrl_low;
    logic          run, fast, clr, gate;
    prs_state_e    state;

    prs_ramp_acc #(.RW(RW), .FAST_STEP(FAST_STEP), .SLOW_STEP(SLOW_STEP)) acc_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .run(run), .fast(fast),
        .ramp_nxt(ramp_nxt)
    );

    prs_level_cmp #(.RW(RW), .ON_LVL(ON_LVL), .END_LVL(END_LVL)) cmp_i (
        .ramp_nxt(ramp_nxt), .ctrl_lvl(ctrl_lvl), .on_hit(on_hit),
        .off_hit(off_hit), .end_hit(end_hit), .ctrl_low(ctrl_low)
    );

    prs_seq_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .zc_stb(zc_stb), .en(en), .gate_inh(gate_inh),
        .on_hit(on_hit), .off_hit(off_hit), .end_hit(end_hit), .ctrl_low(ctrl_low),
        .state(state), .run(run), .fast(fast), .clr(clr), .gate(gate)
    );

    // Output mapping.
    always_comb begin
        gate_out = gate;
        state_o  = state;
    end
endmodule

// File: rtl/prs_checker.sv
// Port-level property checker for the sequencer, bound to every instance.
module prs_checker #(
    parameter int RW     = 12,
    parameter int ON_LVL = 368
) (
    input logic          clk,
    input logic          rst_n,
    input logic          zc_stb,
    input logic          en,
    input logic          gate_inh,
    input logic [RW-1:0] ctrl_lvl,
    input logic          gate_out,
    input logic [2:0]    state_o
);
    AST_ZC_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && zc_stb && en) |=> (state_o == 3'd1)); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd0 && !(zc_stb && en)) |=> (state_o == 3'd0)); // R1
    AST_GATE_IN_COND: assert property (@(posedge clk) disable iff (!rst_n)
        gate_out |-> (state_o == 3'd2)); // R3
    AST_DISCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4) |=> (state_o == 3'd0)); // R5
    AST_INH_NOW: assert property (@(posedge clk) disable iff (!rst_n)
        gate_inh |-> !gate_out); // R6
    AST_INH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_inh && state_o != 3'd0 && state_o != 3'd4) |=> !gate_out); // R6
    AST_BUSY_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (zc_stb && state_o == 3'd3) |=> (state_o != 3'd1)); // R7
    AST_LOW_CTRL_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && ctrl_lvl <= RW'(ON_LVL)) |=> (state_o != 3'd2)); // R8
    AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        state_o <= 3'd4); // R9
endmodule

bind phase_ramp_seq prs_checker #(.RW(RW), .ON_LVL(ON_LVL)) chk_i (
    .clk(clk), .rst_n(rst_n), .zc_stb(zc_stb), .en(en), .gate_inh(gate_inh),
    .ctrl_lvl(ctrl_lvl), .gate_out(gate_out), .state_o(state_o)
);

// File: tb/phase_ramp_seq_tb_top.sv
// Self-checking bench: vector table of control words with expected phase
// lengths, then directed tests for reset, enable, inhibit and stray strobes.
module phase_ramp_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        zc_stb = 1'b0;
    logic [11:0] ctrl_lvl = 12'd0;
    logic        en = 1'b1;
    logic        gate_inh = 1'b0;
    logic        gate_out;
    logic [2:0]  state_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int n_pre, n_cond, n_post, n_disch, n_gate;

    // Rows: ctrl, pre cycles, gate cycles, conduct cycles, post cycles.
    localparam int VEC_N = 7;
    localparam int VEC [VEC_N][5] = '{
        '{400,  92, 32,   32,   900},
        '{1000, 92, 632,  632,  750},
        '{2048, 92, 1680, 1680, 488},
        '{369,  92, 1,    1,    908},
        '{4000, 92, 3632, 3632, 1},
        '{368,  92, 0,    0,    908},
        '{100,  92, 0,    0,    908}
    };

    always #2 clk = ~clk;

    phase_ramp_seq dut_i (
        .clk(clk), .rst_n(rst_n), .zc_stb(zc_stb), .ctrl_lvl(ctrl_lvl),
        .en(en), .gate_inh(gate_inh), .gate_out(gate_out), .state_o(state_o)
    );

    // Watchdog: an expired run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            total = total + 1;
            bad = bad + 1;
            $display("FAIL watchdog: act=%0d exp<150000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    // One half-wave: strobe, then count samples per state until idle.
    task automatic run_half(input int ctrl, input int inh_at, input int zc_at);
        int idx;
        n_pre = 0; n_cond = 0; n_post = 0; n_disch = 0; n_gate = 0;
        @(negedge clk);
        ctrl_lvl = 12'(ctrl);
        zc_stb = 1'b1;
        @(negedge clk);
        zc_stb = 1'b0;
        idx = 0;
        while (state_o != 3'd0 && idx < 20000) begin
            case (state_o)
                3'd1: n_pre++;
                3'd2: n_cond++;
                3'd3: n_post++;
                3'd4: n_disch++;
                default: ;
            endcase
            if (gate_out) n_gate++;
            gate_inh = (idx == inh_at);
            zc_stb = (idx == zc_at);
            @(negedge clk);
            idx++;
        end
        gate_inh = 1'b0;
        zc_stb = 1'b0;
    endtask

    initial begin
        // R9: reset state.
        repeat (3) @(negedge clk);
        check("R9 reset state", int'(state_o), 0);
        check("R9 reset gate", int'(gate_out), 0);
        rst_n = 1'b1;

        // Vector table walk.
        for (int i = 0; i < VEC_N; i++) begin
            run_half(VEC[i][0], -1, -1);
            check("R2 pre length", n_pre, VEC[i][1]);
            if (VEC[i][0] <= 368) begin
                check("R8 no gate", n_gate, VEC[i][2]);
                check("R8 no conduct", n_cond, VEC[i][3]);
            end else begin
                check("R3 gate width", n_gate, VEC[i][2]);
                check("R3 conduct length", n_cond, VEC[i][3]);
            end
            check("R4 post length", n_post, VEC[i][4]);
            check("R5 discharge length", n_disch, 1);
        end

        // R1: strobe with en low is ignored.
        en = 1'b0;
        @(negedge clk);
        zc_stb = 1'b1;
        @(negedge clk);
        zc_stb = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 en low stays idle", int'(state_o), 0);
        en = 1'b1;

        // R1: enabled strobe starts the pre ramp next cycle.
        zc_stb = 1'b1;
        @(negedge clk);
        zc_stb = 1'b0;
        check("R1 start pre", int'(state_o), 1);
        while (state_o != 3'd0) @(negedge clk);

        // R7: stray strobes during conduct and discharge are ignored.
        run_half(1000, -1, 200);
        check("R7 gate width unchanged", n_gate, 632);
        check("R7 post unchanged", n_post, 750);
        repeat (3) @(negedge clk);
        check("R7 idle after stray strobe", int'(state_o), 0);
        run_half(1000, -1, 92 + 632 + 750);
        repeat (3) @(negedge clk);
        check("R7 strobe in discharge ignored", int'(state_o), 0);

        // R6: inhibit mid-conduction blanks rest of half-wave only.
        run_half(1000, 102, -1);
        check("R6 gate cut by inhibit", n_gate, 11);
        check("R6 conduct timing kept", n_cond, 632);
        check("R6 post timing kept", n_post, 750);
        run_half(1000, -1, -1);
        check("R6 next half-wave normal", n_gate, 632);

        // R6: inhibit during pre ramp suppresses the whole pulse.
        run_half(2048, 10, -1);
        check("R6 inhibit in pre", n_gate, 0);
        check("R6 conduct still runs", n_cond, 1680);

        // R9: reset in the middle of conduction.
        @(negedge clk);
        ctrl_lvl = 12'd2048;
        zc_stb = 1'b1;
        @(negedge clk);
        zc_stb = 1'b0;
        repeat (150) @(negedge clk);
        check("R3 gate high mid conduct", int'(gate_out), 1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 mid-run reset state", int'(state_o), 0);
        check("R9 mid-run reset gate", int'(gate_out), 0);
        rst_n = 1'b1;
        run_half(400, -1, -1);
        check("R9 normal after reset", n_gate, 32);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule